// File: doc/BRIEF.md
# Serial Transceiver Channel Reset Sequencer

This block brings one serial transceiver channel out of power-up in a fixed, condition-gated order. The receiver uses automatic clock-data-recovery lock. The sequencer first holds the transmit PLL powered down for a minimum number of clock cycles. It then releases the transmit digital reset once the PLL reports lock. Next it releases the receiver analog reset once the reconfiguration logic is idle. Last, it releases the receiver digital reset once the recovered clock is frequency-locked, a settle delay has run, and incoming data is actually present. Only then does it flag the channel as ready for traffic.

All four status inputs are treated as asynchronous and pass through two-flop synchronizers. If the PLL loses lock once transmit reset is released, the whole sequence restarts from power-down. If frequency lock drops once the receiver analog reset is released, only the receiver digital stage is rolled back. The minimum power-down hold and the settle delay are parameters counted in clock cycles. Defaults are 8 and 6.

Top module: `xcvr_rst_seq`

## Requirements
- R1: After synchronous reset is released, `pll_pwrdn` stays high for exactly PD_HOLD_CYC clock edges and falls on edge PD_HOLD_CYC. On a restart after lock loss it is held for the same count of edges from its re-entry.
- R2: While `pll_pwrdn` is high, `tx_dig_rst`, `rx_ana_rst` and `rx_dig_rst` are all high and `chan_ready` is low.
- R3: `tx_dig_rst` falls only after `pll_pwrdn` has fallen and the synchronized PLL lock input is high. With lock held low it never falls.
- R4: `rx_ana_rst` falls only after `tx_dig_rst` has fallen and the synchronized busy input is low. While busy stays high it remains asserted.
- R5: Once `rx_ana_rst` has fallen, `rx_dig_rst` stays high for as long as frequency lock is low.
- R6: A rising edge of frequency lock, with data present and no other change, makes `rx_dig_rst` fall exactly SETTLE_CYC+4 edges later. This is 2 synchronizer edges, SETTLE_CYC edges of settling, 1 edge for the data check and 1 edge to release.
- R7: `rx_dig_rst` never falls while the synchronized data-present input is low.
- R8: `chan_ready` is high exactly when the sequence is complete. It is never high while `rx_dig_rst` is high, and it rises on the same edge that `rx_dig_rst` falls.
- R9: Every status input passes through two flops. A change at an input reaches the outputs on the third rising edge after it, not earlier.
- R10: If PLL lock is lost after `tx_dig_rst` has fallen, the block returns to power-down. It reasserts `pll_pwrdn` and all resets and drops `chan_ready` 3 edges after the input falls, then repeats the full sequence.
- R11: If frequency lock is lost after `rx_ana_rst` has fallen, `rx_dig_rst` is reasserted and `chan_ready` cleared. The settle delay then restarts from zero on the next rise of frequency lock.
- R12: An active-high synchronous `rst` forces power-down with all four reset outputs high and `chan_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| txpll_lock | input | 1 | Transmit PLL lock status (asynchronous) |
| cfg_busy | input | 1 | Reconfiguration busy flag (asynchronous) |
| rx_freq_lock | input | 1 | Receiver CDR frequency-lock status (asynchronous) |
| rx_data_seen | input | 1 | Data-present qualifier at the receiver input (asynchronous) |
| pll_pwrdn | output | 1 | Transmit PLL power-down |
| tx_dig_rst | output | 1 | Transmit digital reset |
| rx_ana_rst | output | 1 | Receiver analog reset |
| rx_dig_rst | output | 1 | Receiver digital reset |
| chan_ready | output | 1 | Channel ready for traffic |

## Verification
The bench measures both hold windows to the exact edge. A timer that is off by one, or one that is not cleared when its state is entered, would release power-down or receiver digital reset one edge early or late. The bench also drops frequency lock in the middle of the settle window and checks that a fresh, full-length wait follows. A counter that kept its old count would release the receiver early. Long stalls check that each gate holds: lock held low, busy held high, and frequency lock high with no data. A design that let any stage through on a single condition would release a reset there. Lock loss from the ready state is timed for its three-edge latency and for a full-length repeat of power-down.

// File: rtl/xcvr_rst_pkg.sv
package xcvr_rst_pkg;

  typedef enum logic [2:0] {
    ST_PWRDN     = 3'd0,
    ST_WAIT_LOCK = 3'd1,
    ST_WAIT_IDLE = 3'd2,
    ST_WAIT_FLK  = 3'd3,
    ST_SETTLE    = 3'd4,
    ST_WAIT_DATA = 3'd5,
    ST_READY     = 3'd6
  } seq_state_t;

  // A window of 'limit' cycles is complete when the count entering this
  // cycle is limit-1 (the count was cleared on the entry edge).
  function automatic logic hold_reached(input int unsigned count,
                                        input int unsigned limit);
    return (count + 1) >= limit;
  endfunction

  // Bundle of the four reset-style outputs plus ready.
  typedef struct packed {
    logic pwrdn;
    logic tx_dig;
    logic rx_ana;
    logic rx_dig;
    logic ready;
  } seq_out_t;

endpackage

// File: rtl/xrs_sync2.sv
module xrs_sync2 #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[b] <= 1'b0;
        sync_q[b] <= 1'b0;
      end else begin
        meta_q[b] <= d[b];
        sync_q[b] <= meta_q[b];
      end
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/xrs_hold_timer.sv
module xrs_hold_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          done
);
  import xcvr_rst_pkg::*;

  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt_q <= '0;
    else if (cnt_q != CMAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign done = hold_reached(32'(cnt_q), 32'(limit));

  // The count never skips: after a clear the next value is 0 or the clear persists.
  assert_timer_clears_R11: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/xrs_out_decode.sv
module xrs_out_decode (
  input  xcvr_rst_pkg::seq_state_t state,
  output xcvr_rst_pkg::seq_out_t   outs
);
  import xcvr_rst_pkg::*;

  always_comb begin
    outs = '{pwrdn: 1'b1, tx_dig: 1'b1, rx_ana: 1'b1, rx_dig: 1'b1, ready: 1'b0};
    unique case (state)
      ST_PWRDN:     ;
      ST_WAIT_LOCK: outs.pwrdn = 1'b0;
      ST_WAIT_IDLE: begin
        outs.pwrdn  = 1'b0;
        outs.tx_dig = 1'b0;
      end
      ST_WAIT_FLK, ST_SETTLE, ST_WAIT_DATA: begin
        outs.pwrdn  = 1'b0;
        outs.tx_dig = 1'b0;
        outs.rx_ana = 1'b0;
      end
      ST_READY: outs = '{pwrdn: 1'b0, tx_dig: 1'b0, rx_ana: 1'b0, rx_dig: 1'b0, ready: 1'b1};
      default: ;
    endcase
  end
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
  parameter int PD_HOLD_CYC = 8,
  parameter int SETTLE_CYC  = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic txpll_lock,
  input  logic cfg_busy,
  input  logic rx_freq_lock,
  input  logic rx_data_seen,
  output logic pll_pwrdn,
  output logic tx_dig_rst,
  output logic rx_ana_rst,
  output logic rx_dig_rst,
  output logic chan_ready
);
  import xcvr_rst_pkg::*;

  localparam int MAXC = (PD_HOLD_CYC > SETTLE_CYC) ? PD_HOLD_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int NSTAT = 4;

  // synchronized status, bit order {lock, busy, freq lock, data}
  logic [NSTAT-1:0] stat_s;
  logic lock_s, busy_s, flock_s, data_s;

  xrs_sync2 #(.WIDTH(NSTAT)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({txpll_lock, cfg_busy, rx_freq_lock, rx_data_seen}),
    .q   (stat_s)
  );
  assign {lock_s, busy_s, flock_s, data_s} = stat_s;

  seq_state_t state_q, state_d;
  logic          hold_done;
  logic          state_change;
  logic [CW-1:0] hold_limit;

  assign hold_limit   = (state_q == ST_PWRDN) ? CW'(PD_HOLD_CYC) : CW'(SETTLE_CYC);
  assign state_change = (state_d != state_q);

  xrs_hold_timer #(.CW(CW)) i_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (state_change),
    .limit (hold_limit),
    .done  (hold_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_PWRDN:     if (hold_done) state_d = ST_WAIT_LOCK;
      ST_WAIT_LOCK: if (lock_s)    state_d = ST_WAIT_IDLE;
      default: begin
        if (!lock_s) begin
          state_d = ST_PWRDN;
        end else begin
          case (state_q)
            ST_WAIT_IDLE: if (!busy_s) state_d = ST_WAIT_FLK;
            ST_WAIT_FLK:  if (flock_s) state_d = ST_SETTLE;
            ST_SETTLE: begin
              if (!flock_s)      state_d = ST_WAIT_FLK;
              else if (hold_done) state_d = ST_WAIT_DATA;
            end
            ST_WAIT_DATA: begin
              if (!flock_s)     state_d = ST_WAIT_FLK;
              else if (data_s)  state_d = ST_READY;
            end
            ST_READY: if (!flock_s) state_d = ST_WAIT_FLK;
            default:  state_d = ST_PWRDN;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_PWRDN;
    else     state_q <= state_d;
  end

  seq_out_t outs;
  xrs_out_decode i_dec (
    .state (state_q),
    .outs  (outs)
  );

  assign pll_pwrdn  = outs.pwrdn;
  assign tx_dig_rst = outs.tx_dig;
  assign rx_ana_rst = outs.rx_ana;
  assign rx_dig_rst = outs.rx_dig;
  assign chan_ready = outs.ready;

  // ---------------- assertions ----------------
  assert_pwrdn_hold_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_pwrdn) |-> $past(hold_done));

  assert_pwrdn_all_rst_R2: assert property (@(posedge clk) disable iff (rst)
    pll_pwrdn |-> (tx_dig_rst && rx_ana_rst && rx_dig_rst && !chan_ready));

  assert_tx_needs_lock_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_dig_rst) |-> $past(lock_s));

  assert_rxa_needs_idle_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_ana_rst) |-> ($past(!busy_s) && !tx_dig_rst));

  assert_rxd_needs_flock_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_dig_rst) |-> $past(flock_s));

  assert_rxd_needs_data_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_dig_rst) |-> $past(data_s));

  assert_ready_vs_rxd_R8: assert property (@(posedge clk) disable iff (rst)
    chan_ready == !rx_dig_rst);

  assert_lock_loss_R10: assert property (@(posedge clk) disable iff (rst)
    (!lock_s && !tx_dig_rst) |=> (pll_pwrdn && !chan_ready));

  assert_flock_loss_R11: assert property (@(posedge clk) disable iff (rst)
    (lock_s && !flock_s && !rx_ana_rst) |=> (rx_dig_rst && !chan_ready));

  assert_sync_reset_R12: assert property (@(posedge clk)
    rst |=> (pll_pwrdn && tx_dig_rst && rx_ana_rst && rx_dig_rst && !chan_ready));
endmodule

// File: tb/test_xcvr_rst_seq.sv
module test_xcvr_rst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PDH = 8;
  localparam int STL = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock = 1'b0, busy = 1'b1, flk = 1'b0, dat = 1'b0;
  logic pd, txr, rxa, rxd, rdy;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_rst_seq #(.PD_HOLD_CYC(PDH), .SETTLE_CYC(STL)) i_xcvr_rst_seq (
    .clk(clk), .rst(rst), .txpll_lock(lock), .cfg_busy(busy),
    .rx_freq_lock(flk), .rx_data_seen(dat),
    .pll_pwrdn(pd), .tx_dig_rst(txr), .rx_ana_rst(rxa),
    .rx_dig_rst(rxd), .chan_ready(rdy)
  );

  // {lock,busy,flk,dat} [16:13], wait cycles [12:5], expected {pd,tx,rxa,rxd,rdy} [4:0]
  localparam logic [16:0] TBL [0:8] = '{
    {4'b0100, 8'd50, 5'b01110},  // R3: no lock, tx stays in reset
    {4'b1100, 8'd6,  5'b00110},  // R4: locked but busy
    {4'b1000, 8'd40, 5'b00010},  // R5: idle, no freq lock
    {4'b1010, 8'd40, 5'b00010},  // R7: freq lock, no data
    {4'b1011, 8'd6,  5'b00001},  // R8: data arrives, ready
    {4'b1001, 8'd6,  5'b00010},  // R11: freq lock lost
    {4'b1011, 8'd14, 5'b00001},  // R6: relock after settle
    {4'b0011, 8'd5,  5'b11110},  // R10: pll lock lost
    {4'b1011, 8'd30, 5'b00001}   // R10: full sequence repeats
  };

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] got;
    got = {pd, txr, rxa, rxd, rdy};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_bit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(3);
  endtask

  initial begin
    @(negedge clk);
    // R12: reset state
    do_reset();
    chk("R12", 5'b11110);

    // R1: exact power-down hold after reset release, lock already present
    lock = 1'b1;
    cyc(1);
    rst = 1'b0;
    cyc(PDH - 1);
    chk_bit("R1", pd, 1'b1);
    chk("R2", 5'b11110);
    cyc(1);
    chk_bit("R1", pd, 1'b0);
    // R4: busy held high keeps rx analog reset on
    cyc(40);
    chk("R4", 5'b00110);

    // table walk from a fresh reset
    lock = 1'b0; busy = 1'b1; flk = 1'b0; dat = 1'b0;
    do_reset();
    rst = 1'b0;
    for (int i = 0; i < 9; i++) begin
      {lock, busy, flk, dat} = TBL[i][16:13];
      cyc(int'(TBL[i][12:5]));
      chk($sformatf("table step %0d (R2-R11)", i), TBL[i][4:0]);
    end

    // R6 / R9: exact settle window from a freq-lock rise
    flk = 1'b0;
    cyc(6);
    chk("R11", 5'b00010);
    flk = 1'b1;
    cyc(STL + 3);
    chk_bit("R6", rxd, 1'b1);
    cyc(1);
    chk_bit("R6", rxd, 1'b0);
    chk_bit("R8", rdy, 1'b1);

    // R11: loss in mid-settle restarts the full window
    flk = 1'b0;
    cyc(6);
    flk = 1'b1;
    cyc(5);
    flk = 1'b0;
    cyc(3);
    chk("R11", 5'b00010);
    flk = 1'b1;
    cyc(STL + 3);
    chk_bit("R11", rxd, 1'b1);
    cyc(1);
    chk_bit("R11", rxd, 1'b0);

    // R9 / R10: lock loss latency and full-length repeat of power-down
    lock = 1'b0;
    cyc(2);
    chk_bit("R9", pd, 1'b0);
    chk_bit("R9", rdy, 1'b1);
    cyc(1);
    chk("R10", 5'b11110);
    lock = 1'b1;
    cyc(PDH - 1);
    chk_bit("R10", pd, 1'b1);
    cyc(1);
    chk_bit("R10", pd, 1'b0);
    cyc(30);
    chk("R10", 5'b00001);

    // R12: synchronous reset from the ready state
    rst = 1'b1;
    cyc(1);
    chk("R12", 5'b11110);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete got=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule